// File: doc/BRIEF.md
# Fine-to-Coarse Residual Transfer Unit

This unit takes one level of a square multigrid hierarchy and produces the right-hand side for the level below it. For every interior point of the fine grid it evaluates how far the current estimate is from satisfying the Poisson equation. That value is the source term minus the five-point discrete Laplacian of the estimate, scaled by a supplied reciprocal of the squared mesh spacing. It then averages those residuals onto a grid whose spacing is twice as large and writes the averaged values into a coarse array.

A controller pulses `start` once both arrays are loaded. The unit then reads the estimate and source arrays through two synchronous read ports with one cycle of latency. It writes every coarse entry once, in row-major order, and pulses `done` when the run is finished. The fine grid has 2^LEVEL + 2 points per side and the coarse grid has 2^(LEVEL-1) + 2. Values are signed fixed point, W bits wide, with FRAC fraction bits.

Top module: `rr_unit`

## Requirements
- R1: While reset is held and after it is released, `done`, `c_we`, `u_rd_en` and `f_rd_en` stay low until `start` is pulsed. In the cycle after `done` these three enables are low.
- R2: One run writes each coarse address exactly once. Addresses are flat, row*NC + col, with NC = 2^(LEVEL-1) + 2. The writes come in increasing address order, one write per `c_we` cycle.
- R3: Coarse entries on the outer ring (row or column equal to 0 or NC-1) are written as zero.
- R4: The fine residual at interior point (r,c) is f - ((4u[r][c] - u[r-1][c] - u[r+1][c] - u[r][c-1] - u[r][c+1]) * inv_h2 >>> FRAC). The shift is arithmetic, rounding toward minus infinity. Fine addresses are flat, row*N + col, with N = 2^LEVEL + 2. Fine boundary points count as residual zero, and the source array is read only at interior fine addresses.
- R5: A residual outside the signed W-bit range is clamped to the nearest limit (-2^(W-1) or 2^(W-1)-1) rather than wrapped.
- R6: Coarse interior entry (I,J) is the weighted sum over the 3x3 fine residuals centred on fine point (2I-1, 2J-1), using weight 4 at the centre, 2 on the edges and 1 at the corners. The sum is shifted arithmetically right by 4.
- R7: `done` is high for exactly one cycle, and that cycle is the one directly after the write of the last coarse address, NC*NC-1.
- R8: A new `start` after `done` begins a fresh run. Its results depend only on the present array contents and `inv_h2`, never on an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| inv_h2 | input | W | Signed 1/h^2 with FRAC fraction bits |
| done | output | 1 | One-cycle completion pulse |
| u_rd_en | output | 1 | Estimate array read enable |
| u_addr | output | clog2(N*N) | Estimate array flat address |
| u_rdata | input | W | Estimate data, valid one cycle after the address |
| f_rd_en | output | 1 | Source array read enable |
| f_addr | output | clog2(N*N) | Source array flat address |
| f_rdata | input | W | Source data, valid one cycle after the address |
| c_we | output | 1 | Coarse array write strobe |
| c_addr | output | clog2(NC*NC) | Coarse array flat address |
| c_wdata | output | W | Coarse right-hand side value |

## Verification
A coarse ring entry is written in the cycle it is reached. An interior entry is written once its nine taps are done, at six cycles per interior tap and one per boundary tap. The read data are expected one cycle after each address, and the bench's array model returns them on exactly that edge. The bench samples `c_we`, `c_addr` and `c_wdata` at the falling edge of every cycle, so each write is captured in the cycle it is issued. It then requires `done` in the very next sampled cycle after the write to the last address. All coarse contents are compared only after `done`, against values the bench computes from the formulas in R4 to R6.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_POINT = 3'd1,
    ST_TAP   = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } rr_state_e;

  // phase of an interior tap at which the last neighbour sample returns
  localparam logic [2:0] LAST_PHASE = 3'd5;

  // log2 of the full-weighting weight for tap (row, col) in 0..2
  function automatic logic [1:0] tap_shift(input logic [1:0] tr, input logic [1:0] tc);
    return {1'b0, (tr == 2'd1)} + {1'b0, (tc == 2'd1)};
  endfunction

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rr_stencil.sv
module rr_stencil #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic [2:0]          ph,
  input  logic signed [W-1:0] u_rdata,
  input  logic signed [W-1:0] f_rdata,
  input  logic signed [W-1:0] inv_h2,
  output logic signed [W-1:0] res
);
  localparam int LW = W + 3;
  localparam int PW = LW + W;
  localparam int DW = PW + 1;
  localparam longint MAXL = (longint'(1) << (W - 1)) - 1;
  localparam longint MINL = -(longint'(1) << (W - 1));

  logic signed [W-1:0]  ctr_q, fval_q;
  logic signed [LW-1:0] nsum_q, nsum_d;
  logic en_ctr, en_nsum;

  logic signed [LW-1:0] lap;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] diff;

  always_comb begin
    en_ctr  = cap && (ph == 3'd1);
    en_nsum = cap && (ph >= 3'd2) && (ph <= 3'd4);
    nsum_d  = (ph == 3'd2) ? LW'(u_rdata) : nsum_q + LW'(u_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q  <= '0;
      fval_q <= '0;
    end else if (en_ctr) begin
      ctr_q  <= u_rdata;
      fval_q <= f_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nsum_q <= '0;
    else if (en_nsum) nsum_q <= nsum_d;
  end

  // valid in the phase where the fourth neighbour arrives on u_rdata
  always_comb begin
    lap    = (LW'(ctr_q) <<< 2) - (nsum_q + LW'(u_rdata));
    prod   = PW'(lap) * PW'(inv_h2);
    scaled = prod >>> FRAC;
    diff   = DW'(fval_q) - DW'(scaled);
    if (diff > DW'(MAXL))      res = W'(MAXL);
    else if (diff < DW'(MINL)) res = W'(MINL);
    else                       res = W'(diff);
  end
endmodule

// File: rtl/rr_restrict_acc.sv
module rr_restrict_acc #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                add,
  input  logic [1:0]          shift,
  input  logic signed [W-1:0] res,
  output logic signed [W-1:0] avg
);
  localparam int AW = W + 5;

  logic signed [AW-1:0] acc_q, acc_d, term;

  always_comb begin
    term  = AW'(res) <<< shift;
    acc_d = clr ? '0 : acc_q + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || add) acc_q <= acc_d;
  end

  logic signed [AW-1:0] acc_sh;
  assign acc_sh = acc_q >>> 4;
  assign avg    = W'(acc_sh);
endmodule

// File: rtl/rr_unit.sv
module rr_unit #(
  parameter int LEVEL = 3,
  parameter int W     = 16,
  parameter int FRAC  = 8,
  localparam int N    = (1 << LEVEL) + 2,
  localparam int NC   = (1 << (LEVEL - 1)) + 2,
  localparam int FAW  = $clog2(N * N),
  localparam int CAW  = $clog2(NC * NC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   inv_h2,
  output logic           done,
  output logic           u_rd_en,
  output logic [FAW-1:0] u_addr,
  input  logic [W-1:0]   u_rdata,
  output logic           f_rd_en,
  output logic [FAW-1:0] f_addr,
  input  logic [W-1:0]   f_rdata,
  output logic           c_we,
  output logic [CAW-1:0] c_addr,
  output logic [W-1:0]   c_wdata
);
  import rr_pkg::*;

  localparam int CIW = $clog2(NC);
  localparam int FW  = $clog2(N) + 1;

  logic rst_s;
  rr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  rr_state_e st_q, st_d;
  logic [CIW-1:0] ci_q, ci_d, cj_q, cj_d;
  logic [1:0] tr_q, tr_d, tc_q, tc_d;
  logic [2:0] ph_q, ph_d;
  logic acc_clr, acc_add;

  logic c_bound, last_point, last_tap, f_int;
  logic [FW-1:0] fr, fc, rd_row, rd_col;
  logic signed [W-1:0] res, avg;

  // geometry of the current coarse point and fine tap
  always_comb begin
    c_bound    = (ci_q == '0) || (ci_q == CIW'(NC - 1)) ||
                 (cj_q == '0) || (cj_q == CIW'(NC - 1));
    last_point = (ci_q == CIW'(NC - 1)) && (cj_q == CIW'(NC - 1));
    last_tap   = (tr_q == 2'd2) && (tc_q == 2'd2);
    fr         = (FW'(ci_q) <<< 1) + FW'(tr_q) - FW'(2);
    fc         = (FW'(cj_q) <<< 1) + FW'(tc_q) - FW'(2);
    f_int      = (fr != '0) && (fr < FW'(N - 1)) && (fc != '0) && (fc < FW'(N - 1));
  end

  // neighbour selection: centre, up, down, left, right
  always_comb begin
    rd_row = fr;
    rd_col = fc;
    case (ph_q)
      3'd1:    rd_row = fr - FW'(1);
      3'd2:    rd_row = fr + FW'(1);
      3'd3:    rd_col = fc - FW'(1);
      3'd4:    rd_col = fc + FW'(1);
      default: ;
    endcase
  end

  always_comb begin
    u_rd_en = (st_q == ST_TAP) && f_int && (ph_q < LAST_PHASE);
    u_addr  = FAW'(rd_row) * FAW'(N) + FAW'(rd_col);
    f_rd_en = (st_q == ST_TAP) && f_int && (ph_q == 3'd0);
    f_addr  = FAW'(fr) * FAW'(N) + FAW'(fc);
    c_we    = ((st_q == ST_POINT) && c_bound) || (st_q == ST_WRITE);
    c_addr  = CAW'(ci_q) * CAW'(NC) + CAW'(cj_q);
    c_wdata = (st_q == ST_WRITE) ? avg : '0;
    done    = (st_q == ST_DONE);
  end

  // next state
  always_comb begin
    st_d    = st_q;
    ci_d    = ci_q;
    cj_d    = cj_q;
    tr_d    = tr_q;
    tc_d    = tc_q;
    ph_d    = ph_q;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d = ST_POINT;
          ci_d = '0;
          cj_d = '0;
        end
      end
      ST_POINT, ST_WRITE: begin
        if ((st_q == ST_POINT) && !c_bound) begin
          st_d    = ST_TAP;
          tr_d    = '0;
          tc_d    = '0;
          ph_d    = '0;
          acc_clr = 1'b1;
        end else if (last_point) begin
          st_d = ST_DONE;
        end else begin
          st_d = ST_POINT;
          if (cj_q == CIW'(NC - 1)) begin
            cj_d = '0;
            ci_d = ci_q + CIW'(1);
          end else begin
            cj_d = cj_q + CIW'(1);
          end
        end
      end
      ST_TAP: begin
        if (f_int && (ph_q != LAST_PHASE)) begin
          ph_d = ph_q + 3'd1;
        end else begin
          acc_add = f_int;
          ph_d    = '0;
          if (last_tap) begin
            st_d = ST_WRITE;
          end else if (tc_q == 2'd2) begin
            tc_d = '0;
            tr_d = tr_q + 2'd1;
          end else begin
            tc_d = tc_q + 2'd1;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE;
      ci_q <= '0;
      cj_q <= '0;
      tr_q <= '0;
      tc_q <= '0;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ci_q <= ci_d;
      cj_q <= cj_d;
      tr_q <= tr_d;
      tc_q <= tc_d;
      ph_q <= ph_d;
    end
  end

  rr_stencil #(.W(W), .FRAC(FRAC)) u_sten (
    .clk    (clk),
    .rst_n  (rst_s),
    .cap    ((st_q == ST_TAP) && f_int),
    .ph     (ph_q),
    .u_rdata(u_rdata),
    .f_rdata(f_rdata),
    .inv_h2 (inv_h2),
    .res    (res)
  );

  rr_restrict_acc #(.W(W)) u_acc (
    .clk  (clk),
    .rst_n(rst_s),
    .clr  (acc_clr),
    .add  (acc_add),
    .shift(tap_shift(tr_q, tc_q)),
    .res  (res),
    .avg  (avg)
  );
endmodule

// File: rtl/rr_unit_chk.sv
module rr_unit_chk #(
  parameter int LEVEL = 3,
  parameter int W     = 16,
  localparam int N    = (1 << LEVEL) + 2,
  localparam int NC   = (1 << (LEVEL - 1)) + 2,
  localparam int FAW  = $clog2(N * N),
  localparam int CAW  = $clog2(NC * NC)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           u_rd_en,
  input logic           f_rd_en,
  input logic [FAW-1:0] f_addr,
  input logic           c_we,
  input logic [CAW-1:0] c_addr,
  input logic [W-1:0]   c_wdata
);
  int c_row, c_col, f_row, f_col;
  logic c_ring, f_inner;

  always_comb begin
    c_row   = int'(c_addr) / NC;
    c_col   = int'(c_addr) % NC;
    f_row   = int'(f_addr) / N;
    f_col   = int'(f_addr) % N;
    c_ring  = (c_row == 0) || (c_row == NC - 1) || (c_col == 0) || (c_col == NC - 1);
    f_inner = (f_row > 0) && (f_row < N - 1) && (f_col > 0) && (f_col < N - 1);
  end

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(c_we) && ($past(c_addr) == CAW'(NC * NC - 1))));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!c_we && !u_rd_en && !f_rd_en));

  a_r3_ring_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_ring) |-> (c_wdata == '0));

  a_r4_src_interior: assert property (@(posedge clk) disable iff (!rst_n)
    f_rd_en |-> f_inner);

  a_r2_no_write_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> !done);
endmodule

bind rr_unit rr_unit_chk #(.LEVEL(LEVEL), .W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .done   (done),
  .u_rd_en(u_rd_en),
  .f_rd_en(f_rd_en),
  .f_addr (f_addr),
  .c_we   (c_we),
  .c_addr (c_addr),
  .c_wdata(c_wdata)
);

// File: tb/rr_unit_bench.sv
module rr_unit_bench;
  localparam int LEVEL = 3;
  localparam int W     = 16;
  localparam int FRAC  = 8;
  localparam int N     = (1 << LEVEL) + 2;
  localparam int NC    = (1 << (LEVEL - 1)) + 2;
  localparam int FAW   = $clog2(N * N);
  localparam int CAW   = $clog2(NC * NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] inv_h2 = '0;
  logic done, u_rd_en, f_rd_en, c_we;
  logic [FAW-1:0] u_addr, f_addr;
  logic [W-1:0] u_rdata = '0, f_rdata = '0, c_wdata;
  logic [CAW-1:0] c_addr;

  always #10 clk = ~clk;

  rr_unit #(.LEVEL(LEVEL), .W(W), .FRAC(FRAC)) u_rr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_h2(inv_h2), .done(done),
    .u_rd_en(u_rd_en), .u_addr(u_addr), .u_rdata(u_rdata),
    .f_rd_en(f_rd_en), .f_addr(f_addr), .f_rdata(f_rdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata)
  );

  int umem [N*N];
  int fmem [N*N];
  int cmem [NC*NC];
  int wcnt [NC*NC];
  int kval;
  int errors = 0, checks = 0;
  int cyc = 0, seq_idx = 0, last_we_cyc = -10;
  int seed = 7;

  // synchronous read arrays, one cycle latency
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    u_rdata <= W'(umem[u_addr]);
    f_rdata <= W'(fmem[f_addr]);
  end

  // output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n && c_we) begin
      checks++;
      if (int'(c_addr) != seq_idx) begin
        errors++;
        $display("FAIL R2 write order: addr=%0d expected=%0d", c_addr, seq_idx);
      end
      cmem[c_addr] = int'($signed(c_wdata));
      wcnt[c_addr] = wcnt[c_addr] + 1;
      seq_idx++;
      last_we_cyc = cyc;
    end
    if (rst_n && done) begin
      checks++;
      if (cyc != last_we_cyc + 1 || last_we_cyc < 0 || seq_idx != NC * NC) begin
        errors++;
        $display("FAIL R7 done timing: done_cyc=%0d expected=%0d (writes=%0d)",
                 cyc, last_we_cyc + 1, seq_idx);
      end
    end
  end

  function automatic int rnd(input int span);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & (span * 2 - 1)) - span;
  endfunction

  function automatic longint fine_res(input int r, input int c);
    longint lap, p, d;
    if (r <= 0 || r >= N - 1 || c <= 0 || c >= N - 1) return 0;
    lap = 4 * longint'(umem[r*N+c]) - umem[(r-1)*N+c] - umem[(r+1)*N+c]
          - umem[r*N+c-1] - umem[r*N+c+1];
    p = (lap * kval) >>> FRAC;
    d = longint'(fmem[r*N+c]) - p;
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  function automatic int coarse_exp(input int ci, input int cj);
    longint acc = 0;
    if (ci == 0 || cj == 0 || ci == NC - 1 || cj == NC - 1) return 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        acc += fine_res(2*ci - 2 + a, 2*cj - 2 + b) * ((a == 1 ? 2 : 1) * (b == 1 ? 2 : 1));
    return int'(acc >>> 4);
  endfunction

  task automatic run(input string tag);
    int wd = 0;
    for (int i = 0; i < NC * NC; i++) begin
      wcnt[i] = 0;
      cmem[i] = 12345;
    end
    seq_idx = 0;
    last_we_cyc = -10;
    inv_h2 = W'(kval);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 20000) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: done=0 expected=1", tag);
    end
    @(negedge clk);
    for (int i = 0; i < NC; i++)
      for (int j = 0; j < NC; j++) begin
        int e = coarse_exp(i, j);
        bit ring = (i == 0 || j == 0 || i == NC - 1 || j == NC - 1);
        checks++;
        if (cmem[i*NC+j] != e) begin
          errors++;
          $display("FAIL %s coarse(%0d,%0d): actual=%0d expected=%0d",
                   ring ? "R3" : tag, i, j, cmem[i*NC+j], e);
        end
        checks++;
        if (wcnt[i*NC+j] != 1) begin
          errors++;
          $display("FAIL R2 write count (%0d,%0d): actual=%0d expected=1", i, j, wcnt[i*NC+j]);
        end
      end
  endtask

  task automatic check_quiet(input string what);
    checks++;
    if (done || c_we || u_rd_en || f_rd_en) begin
      errors++;
      $display("FAIL R1 %s: done=%0b we=%0b ure=%0b fre=%0b expected all 0",
               what, done, c_we, u_rd_en, f_rd_en);
    end
  endtask

  initial begin
    for (int i = 0; i < N * N; i++) begin umem[i] = 0; fmem[i] = 0; end
    kval = 256;
    repeat (3) @(negedge clk);
    check_quiet("in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_quiet("idle after reset");

    // all zero arrays (R4, R6)
    run("R6");
    @(negedge clk);
    check_quiet("after done");

    // flat estimate: residual equals the source (R4)
    for (int i = 0; i < N * N; i++) begin umem[i] = 100; fmem[i] = rnd(1024); end
    run("R4");

    // mixed moderate values with unit scale (R4, R6)
    for (int i = 0; i < N * N; i++) begin umem[i] = rnd(512); fmem[i] = rnd(512); end
    run("R6");

    // repeat without changes: same results from a fresh run (R8)
    run("R8");

    // fractional scale 0.75 rounding toward minus infinity (R4)
    kval = 192;
    for (int i = 0; i < N * N; i++) begin umem[i] = rnd(256); fmem[i] = rnd(64); end
    run("R4");

    // checkerboard extremes with large scale: clamping (R5)
    kval = 16384;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        umem[r*N+c] = ((r + c) % 2 == 0) ? 30000 : -30000;
        fmem[r*N+c] = rnd(1024);
      end
    run("R5");

    // one-sided extremes so whole neighbourhoods clamp the same way (R5)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        umem[r*N+c] = (r < N / 2) ? 32000 : -32000;
        fmem[r*N+c] = (r < N / 2) ? -32768 : 32767;
      end
    umem[2*N+2] = 32767;
    run("R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule